// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by running two direction predictors side by side and letting a third table decide which one to trust. The first predictor keeps a per-branch history of recent outcomes. A row of that history table is selected by the low word-address bits of the branch, and the history it holds then selects a 2-bit saturating counter. The second predictor keeps one shift register of the most recent outcomes of all branches, and that register selects a 2-bit counter in a larger table. A chooser table of 2-bit saturating counters is selected by the same global history. The upper bit of the selected chooser entry steers a multiplexer between the two component predictions.

The fetch side presents a branch address on the predict port and reads back the final direction. It also reads back the two table indices and the two component predictions, and it keeps them until the branch resolves. On the resolve port it returns the address, the real outcome and those captured values. Both component predictors learn from every resolved branch. The chooser learns only when the two components disagreed, and it moves toward the one that was right.

All table reads are combinational from the current state. All learning happens on the clock edge that samples a valid resolve.

Top module: `tourn_bp`

## Requirements
- R1: After reset every counter in all three tables holds 1 and all histories are zero. The predict port therefore reports not-taken, local selected, local index 0 and global index 0 for any address.
- R2: `pred_lidx` equals the local history held in row `pred_addr`. `pred_lpred` is bit 1 of the local counter at index `pred_lidx`.
- R3: `pred_gidx` equals the global history. `pred_gpred` is bit 1 of the global counter at index `pred_gidx`.
- R4: The chooser entry at the global history selects the output. A value of 2 or 3 makes `pred_use_global` 1 and `pred_taken` equal to `pred_gpred`. A value of 0 or 1 makes `pred_use_global` 0 and `pred_taken` equal to `pred_lpred`.
- R5: Every counter increments on a taken outcome and decrements on a not-taken outcome. It saturates at 3 and at 0.
- R6: A resolve shifts the local history of row `res_addr` left by one. The outcome enters at bit 0 (1 = taken), and the oldest bit drops off.
- R7: A resolve shifts the global history left by one, with the outcome entering at bit 0.
- R8: Every resolve trains the local counter at `res_lidx` and the global counter at `res_gidx`, whichever component was selected.
- R9: The chooser entry at `res_gidx` changes only when `res_lpred` differs from `res_gpred`. It increments when `res_gpred` matched the outcome and decrements otherwise.
- R10: State changes only on a clock edge with `res_valid` high. The predict outputs reflect such an update in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_addr | input | ADDR_W (10) | Low word-address bits of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction |
| pred_use_global | output | 1 | 1 when the global prediction was selected |
| pred_lidx | output | LH_W (10) | Local counter index to hand back on resolve |
| pred_gidx | output | GH_W (12) | Global counter and chooser index to hand back on resolve |
| pred_lpred | output | 1 | Local component prediction |
| pred_gpred | output | 1 | Global component prediction |
| res_valid | input | 1 | Resolve strobe |
| res_addr | input | ADDR_W (10) | Address bits of the resolving branch |
| res_taken | input | 1 | Real outcome, 1 = taken |
| res_lidx | input | LH_W (10) | Captured local index |
| res_gidx | input | GH_W (12) | Captured global index |
| res_lpred | input | 1 | Captured local prediction |
| res_gpred | input | 1 | Captured global prediction |

## Verification
The predict outputs are combinational, so they are due in the same cycle the address is applied. A resolve is due one edge later: its effect appears on the predict port in the cycle after the edge that samples it. The bench drives inputs just after each falling edge and compares all six predict outputs a nanosecond later, against a behavioural model whose state has absorbed every resolve up to the previous rising edge. The model applies a resolve only after it has compared that cycle's outputs. This keeps same-cycle reads and next-cycle updates apart.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_TOP   = 2'd3;
   localparam ctr_t CTR_FLOOR = 2'd0;
   localparam ctr_t CTR_RESET = 2'd1;

   function automatic ctr_t ctr_step(input ctr_t cur, input logic inc);
      ctr_t nxt;
      if (inc) nxt = (cur == CTR_TOP)   ? cur : cur + 2'd1;
      else     nxt = (cur == CTR_FLOOR) ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
   import bp_pkg::*;
#(
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_hi,
   input  logic             up_en,
   input  logic [IDX_W-1:0] up_idx,
   input  logic             up_inc
);
   localparam int DEPTH = 1 << IDX_W;

   ctr_t mem [DEPTH];

   assign rd_hi = mem[rd_idx][1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RESET;
      end else if (up_en) begin
         mem[up_idx] <= ctr_step(mem[up_idx], up_inc);
      end
   end
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
   parameter int ROW_W  = 10,
   parameter int HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_W-1:0]  rd_row,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              sh_en,
   input  logic [ROW_W-1:0]  sh_row,
   input  logic              sh_bit
);
   localparam int ROWS = 1 << ROW_W;

   logic [HIST_W-1:0] hist [ROWS];

   assign rd_hist = hist[rd_row];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ROWS; i++) hist[i] <= '0;
      end else if (sh_en) begin
         hist[sh_row] <= {hist[sh_row][HIST_W-2:0], sh_bit};
      end
   end
endmodule

// File: rtl/bp_ghr.sv
module bp_ghr #(
   parameter int HIST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sh_en,
   input  logic              sh_bit,
   output logic [HIST_W-1:0] hist
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hist <= '0;
      else if (sh_en) hist <= {hist[HIST_W-2:0], sh_bit};
   end
endmodule

// File: rtl/tourn_bp.sv
module tourn_bp #(
   parameter int ADDR_W = 10,
   parameter int LH_W   = 10,
   parameter int GH_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pred_addr,
   output logic              pred_taken,
   output logic              pred_use_global,
   output logic [LH_W-1:0]   pred_lidx,
   output logic [GH_W-1:0]   pred_gidx,
   output logic              pred_lpred,
   output logic              pred_gpred,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_addr,
   input  logic              res_taken,
   input  logic [LH_W-1:0]   res_lidx,
   input  logic [GH_W-1:0]   res_gidx,
   input  logic              res_lpred,
   input  logic              res_gpred
);
   generate
      if (ADDR_W < 1 || ADDR_W > 14) begin : g_bad_addr
         $error("tourn_bp: ADDR_W out of range");
      end
      if (LH_W < 2 || LH_W > 14) begin : g_bad_lh
         $error("tourn_bp: LH_W out of range");
      end
      if (GH_W < 2 || GH_W > 14) begin : g_bad_gh
         $error("tourn_bp: GH_W out of range");
      end
   endgenerate

   logic [LH_W-1:0] lhist;
   logic [GH_W-1:0] ghist;
   logic            lp, gp, pick_g;
   logic            ch_train, ch_up;

   bp_hist_table #(.ROW_W(ADDR_W), .HIST_W(LH_W)) u_lhist (
      .clk(clk), .rst_n(rst_n),
      .rd_row(pred_addr), .rd_hist(lhist),
      .sh_en(res_valid), .sh_row(res_addr), .sh_bit(res_taken)
   );

   bp_ctr_table #(.IDX_W(LH_W)) u_lctr (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lhist), .rd_hi(lp),
      .up_en(res_valid), .up_idx(res_lidx), .up_inc(res_taken)
   );

   bp_ghr #(.HIST_W(GH_W)) u_ghr (
      .clk(clk), .rst_n(rst_n),
      .sh_en(res_valid), .sh_bit(res_taken), .hist(ghist)
   );

   bp_ctr_table #(.IDX_W(GH_W)) u_gctr (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghist), .rd_hi(gp),
      .up_en(res_valid), .up_idx(res_gidx), .up_inc(res_taken)
   );

   assign ch_train = res_valid && (res_lpred != res_gpred);
   assign ch_up    = (res_gpred == res_taken);

   bp_ctr_table #(.IDX_W(GH_W)) u_choose (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghist), .rd_hi(pick_g),
      .up_en(ch_train), .up_idx(res_gidx), .up_inc(ch_up)
   );

   assign pred_lidx       = lhist;
   assign pred_gidx       = ghist;
   assign pred_lpred      = lp;
   assign pred_gpred      = gp;
   assign pred_use_global = pick_g;
   assign pred_taken      = pick_g ? gp : lp;
endmodule

// File: rtl/tourn_bp_chk.sv
module tourn_bp_chk #(
   parameter int ADDR_W = 10,
   parameter int LH_W   = 10,
   parameter int GH_W   = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] pred_addr,
   input logic              pred_taken,
   input logic [LH_W-1:0]   pred_lidx,
   input logic [GH_W-1:0]   pred_gidx,
   input logic              pred_lpred,
   input logic              pred_gpred,
   input logic              res_valid,
   input logic [ADDR_W-1:0] res_addr,
   input logic              res_taken
);
   // R7: global history shifts in the outcome
   a_r7_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> pred_gidx == {$past(pred_gidx[GH_W-2:0]), $past(res_taken)});

   // R6: local history of the resolved row shifts in the outcome
   a_r6_lhist_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_addr == pred_addr) |=>
         (pred_addr != $past(pred_addr)) ||
         (pred_lidx == {$past(pred_lidx[LH_W-2:0]), $past(res_taken)}));

   // R10: no resolve means no change seen at a steady address
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> (pred_addr != $past(pred_addr)) ||
         ($stable(pred_lidx) && $stable(pred_gidx) && $stable(pred_taken)));

   // R4: when the components agree the choice cannot matter
   a_r4_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_lpred == pred_gpred) |-> (pred_taken == pred_lpred));
endmodule

bind tourn_bp tourn_bp_chk #(.ADDR_W(ADDR_W), .LH_W(LH_W), .GH_W(GH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_taken(pred_taken),
   .pred_lidx(pred_lidx), .pred_gidx(pred_gidx), .pred_lpred(pred_lpred),
   .pred_gpred(pred_gpred), .res_valid(res_valid), .res_addr(res_addr),
   .res_taken(res_taken)
);

// File: tb/sim_tourn_bp.sv
`timescale 1ns/1ps
module sim_tourn_bp;
   localparam int AW = 10, LW = 10, GW = 12;
   localparam int NR = 1 << AW, NL = 1 << LW, NG = 1 << GW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0] pred_addr = '0, res_addr = '0;
   logic pred_taken, pred_use_global, pred_lpred, pred_gpred;
   logic [LW-1:0] pred_lidx, res_lidx = '0;
   logic [GW-1:0] pred_gidx, res_gidx = '0;
   logic res_valid = 1'b0, res_taken = 1'b0, res_lpred = 1'b0, res_gpred = 1'b0;

   always #2.5 clk = ~clk;

   tourn_bp #(.ADDR_W(AW), .LH_W(LW), .GH_W(GW)) u0 (.*);

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 1'b0;
   int m_lh[NR]; int m_lc[NL]; int m_gc[NG]; int m_ch[NG]; int m_gh;

   always @(posedge clk) cyc++;

   function automatic int sat(int v, bit up);
      if (up) return (v == 3) ? 3 : v + 1;
      return (v == 0) ? 0 : v - 1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NR; i++) m_lh[i] = 0;
      for (int i = 0; i < NL; i++) m_lc[i] = 1;
      for (int i = 0; i < NG; i++) begin m_gc[i] = 1; m_ch[i] = 1; end
      m_gh = 0;
   endtask

   task automatic model_pred(input int a, output int li, output int gi,
                             output int lp, output int gp, output int ug, output int tk);
      li = m_lh[a]; gi = m_gh;
      lp = m_lc[li] >> 1; gp = m_gc[gi] >> 1; ug = m_ch[gi] >> 1;
      tk = ug ? gp : lp;
   endtask

   task automatic cmp(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   // one cycle: predict pa, optionally resolve (ra, rt, captured values)
   task automatic step(string ph, int pa, bit rv, int ra, bit rt,
                       int rli, int rgi, int rlp, int rgp);
      int li, gi, lp, gp, ug, tk;
      @(negedge clk);
      pred_addr = AW'(pa); res_valid = rv; res_addr = AW'(ra); res_taken = rt;
      res_lidx = LW'(rli); res_gidx = GW'(rgi); res_lpred = rlp[0]; res_gpred = rgp[0];
      #1;
      model_pred(pa, li, gi, lp, gp, ug, tk);
      cmp({ph, " R2 R6 lidx"}, int'(pred_lidx), li);
      cmp({ph, " R3 R7 gidx"}, int'(pred_gidx), gi);
      cmp({ph, " R2 R5 R8 lpred"}, int'(pred_lpred), lp);
      cmp({ph, " R3 R5 R8 gpred"}, int'(pred_gpred), gp);
      cmp({ph, " R4 R9 use_global"}, int'(pred_use_global), ug);
      cmp({ph, " R4 taken"}, int'(pred_taken), tk);
      @(posedge clk);
      if (rv) begin
         m_lc[rli] = sat(m_lc[rli], rt);
         m_gc[rgi] = sat(m_gc[rgi], rt);
         if (rlp != rgp) m_ch[rgi] = sat(m_ch[rgi], rgp == int'(rt));
         m_lh[ra] = ((m_lh[ra] << 1) | int'(rt)) & (NL - 1);
         m_gh = ((m_gh << 1) | int'(rt)) & (NG - 1);
      end
   endtask

   // predict and resolve the same branch with its current prediction
   task automatic pr(string ph, int a, bit t);
      int li, gi, lp, gp, ug, tk;
      model_pred(a, li, gi, lp, gp, ug, tk);
      step(ph, a, 1'b1, a, t, li, gi, lp, gp);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
   end

   initial begin
      int lfsr = 32'h1ace;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: reset state on several addresses
      step("R1 reset", 0, 1'b0, 0, 1'b0, 0, 0, 0, 0);
      step("R1 reset", 777, 1'b0, 0, 1'b0, 0, 0, 0, 0);
      cmp("R1 taken after reset", int'(pred_taken), 0);
      cmp("R1 use_global after reset", int'(pred_use_global), 0);

      // R5 upper saturation, R6/R7 history fill
      for (int i = 0; i < 30; i++) pr("R5 sat-up", 5, 1'b1);
      step("R10 idle", 5, 1'b0, 0, 1'b0, 0, 0, 0, 0);
      cmp("R6 lidx all ones", int'(pred_lidx), NL - 1);
      cmp("R7 gidx all ones", int'(pred_gidx), NG - 1);
      cmp("R5 taken saturated", int'(pred_taken), 1);

      // R5 lower saturation
      for (int i = 0; i < 30; i++) pr("R5 sat-down", 5, 1'b0);
      step("R10 idle", 5, 1'b0, 0, 1'b0, 0, 0, 0, 0);
      cmp("R5 taken low", int'(pred_taken), 0);

      // alternating branch, and two interleaved branches
      for (int i = 0; i < 200; i++) pr("R9 alt", 9, 1'(i & 1));
      for (int i = 0; i < 300; i++) pr("R9 pair", (i & 1) ? 40 : 41, 1'((i % 3) == 0));

      // mixed: different predict/resolve addresses, idle gaps
      for (int i = 0; i < 4000; i++) begin
         int ra, pa, li, gi, lp, gp, ug, tk;
         bit t;
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
         ra = lfsr & 15;
         pa = (lfsr >> 4) & 15;
         t  = ((ra & 1) != 0) ^ ((m_gh & 2) != 0) ^ (((lfsr >> 9) & 7) == 0);
         model_pred(ra, li, gi, lp, gp, ug, tk);
         if ((lfsr & 48) == 48) step("R10 gap", pa, 1'b0, 0, 1'b0, 0, 0, 0, 0);
         else step("R8 mix", pa, 1'b1, ra, t, li, gi, lp, gp);
      end
      summary();
   end
endmodule